// File: doc/BRIEF.md
# Match-Interrupt RTC Seconds Counter

This block is a 32-bit real-time up-counter. It advances one step for each rising edge of a slow reference clock of about 32.768 kHz. That reference arrives on an asynchronous input pin, and the block samples it in the system clock domain. Software selects real-time operation, sets the starting count and a match value, and then starts the counter. When the count reaches the match value, a raw status flag is set and the counter keeps running. The flag can be masked onto an interrupt line, and it is cleared by writing a one.

A write to the load register restarts the count from the written value. The count wraps from all-ones to zero. A stall control can freeze counting while the debug-halt input is high. The register port is a simple single-cycle write strobe with a separate, combinational read address.

Top module: `rtc_match_counter`

## Requirements
- R1: While the run bit (CTRL bit 0) is set, writes to the configuration register (address 0) are ignored. While it is clear, writes are stored and read back unchanged.
- R2: With configuration equal to 1 and CTRL bits 0 (run) and 1 (real-time enable) both set, each rising edge of `ref_clk_i` adds one to the count. The count reads back at address 7 and resets to 0.
- R3: When a counting step makes the count equal the match register (address 2), the raw status bit (address 5, bit 0) is set. Counting continues past the match value unaffected.
- R4: A write to the load register (address 1) places the written value in the count at once. Counting resumes from that value and wraps from 0xFFFF_FFFF to 0.
- R5: Writing 1 to bit 0 of the clear register (address 6) clears the raw status bit.
- R6: `irq_o` is high exactly when the raw status bit and bit 0 of the mask register (address 4) are both set.
- R7: With the stall bit (CTRL bit 2) set, reference edges are not counted while `dbg_halt_i` is high. With the stall bit clear, `dbg_halt_i` has no effect.
- R8: No counting occurs when the run bit is clear, when the real-time enable bit is clear, or when the configuration value is not 1.
- R9: If a clear write and a match-producing step occur in the same cycle, the raw status bit ends up set.
- R10: After reset, all registers, the count, the status bit and `irq_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_clk_i | input | 1 | 32.768 kHz reference, asynchronous to clk_i |
| dbg_halt_i | input | 1 | Debug halt request |
| we_i | input | 1 | Register write strobe |
| waddr_i | input | 3 | Write address |
| wdata_i | input | 32 | Write data |
| raddr_i | input | 3 | Read address |
| rdata_o | output | 32 | Read data for raddr_i |
| irq_o | output | 1 | Masked match interrupt |

## Verification
The reference input is pulsed in groups with different gating settings:
- fully enabled;
- with the run bit, the real-time bit or the configuration value removed;
- with stall on and off while halt is high.

Comparing the counts after each group separates true step gating from a counter that ignores one of its qualifiers.

Loading near all-ones and stepping past it shows that wrap-around happens. Stepping past the match value shows that the flag is set and that the counter does not stop.

A clear write is timed to land in the same cycle as a matching step. This separates set-over-clear priority from the reverse.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CFG   = 3'd0;
  localparam logic [ADDR_W-1:0] A_LOAD  = 3'd1;
  localparam logic [ADDR_W-1:0] A_MATCH = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd3;
  localparam logic [ADDR_W-1:0] A_MASK  = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd5;
  localparam logic [ADDR_W-1:0] A_CLR   = 3'd6;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd7;
  localparam int CTRL_RUN   = 0;
  localparam int CTRL_RTC   = 1;
  localparam int CTRL_STALL = 2;
  localparam int CTRL_W     = 3;
endpackage

// File: rtl/rtc_tick_sync.sv
module rtc_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic tick_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], ref_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign tick_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      cfg_o,
  output logic [W-1:0]      load_o,
  output logic [W-1:0]      match_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              mask_o,
  output logic              load_wr_o,
  output logic              clr_wr_o
);
  logic hit_cfg, hit_load, hit_match, hit_ctrl, hit_mask;

  assign hit_cfg   = we_i && waddr_i == A_CFG;
  assign hit_load  = we_i && waddr_i == A_LOAD;
  assign hit_match = we_i && waddr_i == A_MATCH;
  assign hit_ctrl  = we_i && waddr_i == A_CTRL;
  assign hit_mask  = we_i && waddr_i == A_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o   <= '0;
      load_o  <= '0;
      match_o <= '0;
      ctrl_o  <= '0;
      mask_o  <= 1'b0;
    end else begin
      // configuration is frozen while the timer runs
      if (hit_cfg && !ctrl_o[CTRL_RUN]) cfg_o <= wdata_i;
      if (hit_load)  load_o  <= wdata_i;
      if (hit_match) match_o <= wdata_i;
      if (hit_ctrl)  ctrl_o  <= wdata_i[CTRL_W-1:0];
      if (hit_mask)  mask_o  <= wdata_i[0];
    end
  end

  assign load_wr_o = hit_load;
  assign clr_wr_o  = we_i && waddr_i == A_CLR && wdata_i[0];
endmodule

// File: rtl/rtc_count.sv
module rtc_count #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         load_wr_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] match_i,
  input  logic         clr_i,
  output logic [W-1:0] count_o,
  output logic         stat_o
);
  logic [W-1:0] count_nxt;
  logic         hit;

  assign count_nxt = count_o + 1'b1;
  assign hit       = step_i && !load_wr_i && count_nxt == match_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
      stat_o  <= 1'b0;
    end else begin
      if (load_wr_i)   count_o <= load_val_i;
      else if (step_i) count_o <= count_nxt;
      // set wins over clear
      if (hit)        stat_o <= 1'b1;
      else if (clr_i) stat_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_match_counter.sv
module rtc_match_counter
  import rtc_pkg::*;
#(
  parameter int W           = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_clk_i,
  input  logic              dbg_halt_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [W-1:0]      rdata_o,
  output logic              irq_o
);
  logic              tick;
  logic [W-1:0]      cfg_q, load_q, match_q, count_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              mask_q, stat_q, load_wr, clr_wr, step, frozen;

  rtc_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .ref_i(ref_clk_i), .tick_o(tick)
  );

  rtc_regs #(.W(W)) u_regs (
    .clk_i, .rst_ni, .we_i, .waddr_i, .wdata_i,
    .cfg_o(cfg_q), .load_o(load_q), .match_o(match_q), .ctrl_o(ctrl_q),
    .mask_o(mask_q), .load_wr_o(load_wr), .clr_wr_o(clr_wr)
  );

  assign frozen = ctrl_q[CTRL_STALL] && dbg_halt_i;
  assign step   = tick && ctrl_q[CTRL_RUN] && ctrl_q[CTRL_RTC] &&
                  cfg_q == W'(1) && !frozen;

  rtc_count #(.W(W)) u_cnt (
    .clk_i, .rst_ni, .step_i(step), .load_wr_i(load_wr),
    .load_val_i(wdata_i), .match_i(match_q), .clr_i(clr_wr),
    .count_o(count_q), .stat_o(stat_q)
  );

  assign irq_o = stat_q & mask_q;

  always_comb begin
    unique case (raddr_i)
      A_CFG:   rdata_o = cfg_q;
      A_LOAD:  rdata_o = load_q;
      A_MATCH: rdata_o = match_q;
      A_CTRL:  rdata_o = W'(ctrl_q);
      A_MASK:  rdata_o = W'(mask_q);
      A_STAT:  rdata_o = W'(stat_q);
      A_COUNT: rdata_o = count_q;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rtc_match_counter_chk.sv
module rtc_match_counter_chk
  import rtc_pkg::*;
#(
  parameter int W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] waddr_i,
  input logic [W-1:0]      wdata_i,
  input logic              irq_o,
  input logic              step,
  input logic              load_wr,
  input logic              clr_wr,
  input logic [W-1:0]      count_q,
  input logic [W-1:0]      match_q,
  input logic [W-1:0]      cfg_q,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic              stat_q,
  input logic              mask_q
);
  a_r1_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[CTRL_RUN] && we_i && waddr_i == A_CFG) |=> $stable(cfg_q));

  a_r2_step_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !load_wr) |=> count_q == $past(count_q) + 1'b1);

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step && !load_wr) |=> $stable(count_q));

  a_r4_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_wr |=> count_q == $past(wdata_i));

  a_r3_match_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !load_wr && count_q + 1'b1 == match_q) |=> stat_q);

  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr && !(step && !load_wr && count_q + 1'b1 == match_q)) |=> !stat_q);

  a_r6_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q && mask_q) |-> irq_o);

  a_r6_irq_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (stat_q && mask_q));
endmodule

bind rtc_match_counter rtc_match_counter_chk #(.W(W)) u_chk (.*);

// File: tb/rtc_match_counter_bench.sv
`timescale 1ns/1ps
module rtc_match_counter_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ref_clk_i = 1'b0;
  logic        dbg_halt_i = 1'b0;
  logic        we_i = 1'b0;
  logic [2:0]  waddr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [2:0]  raddr_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  rtc_match_counter u_rtc_match_counter (.*);

  always #2 clk_i = ~clk_i;

  typedef struct {
    logic [2:0]  addr;
    logic [31:0] exp;
    logic        is_irq;
    string       tag;
  } item_t;

  item_t q[$];
  int    n_run = 0, n_fail = 0, pending = 0;
  bit    done = 0;

  // monitor: pops expected items and compares against the design
  initial begin
    forever begin
      @(negedge clk_i);
      if (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        raddr_i = it.addr;
        #1;
        act = it.is_irq ? {31'd0, irq_o} : rdata_o;
        n_run++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
        pending--;
      end
    end
  end

  task automatic expect_rd(input logic [2:0] a, input logic [31:0] e, input string t);
    item_t it;
    it.addr = a; it.exp = e; it.is_irq = 1'b0; it.tag = t;
    pending++;
    q.push_back(it);
    wait (pending == 0);
  endtask

  task automatic expect_irq(input logic e, input string t);
    item_t it;
    it.addr = 3'd0; it.exp = {31'd0, e}; it.is_irq = 1'b1; it.tag = t;
    pending++;
    q.push_back(it);
    wait (pending == 0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; waddr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i) ref_clk_i = 1'b1;
      repeat (4) @(negedge clk_i);
      ref_clk_i = 1'b0;
      repeat (4) @(negedge clk_i);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R10 reset state
    expect_rd(3'd7, 32'd0, "R10 count");
    expect_rd(3'd5, 32'd0, "R10 status");
    expect_irq(1'b0, "R10 irq");

    // R8: run+rtc set but config 0 -> no counting
    wr(3'd3, 32'h3);
    ticks(2);
    expect_rd(3'd7, 32'd0, "R8 cfg not 1");
    wr(3'd3, 32'h0);
    wr(3'd0, 32'h1);
    expect_rd(3'd0, 32'h1, "R1 cfg stored while stopped");
    // R8: run only, rtc enable clear
    wr(3'd3, 32'h1);
    ticks(2);
    expect_rd(3'd7, 32'd0, "R8 rtc enable clear");
    // R1: cfg write ignored while running
    wr(3'd0, 32'h0);
    expect_rd(3'd0, 32'h1, "R1 cfg write ignored");

    // R2 counting
    wr(3'd3, 32'h3);
    ticks(3);
    expect_rd(3'd7, 32'd3, "R2 three steps");

    // R3 match, R6 masking
    wr(3'd2, 32'd5);
    ticks(2);
    expect_rd(3'd7, 32'd5, "R3 count at match");
    expect_rd(3'd5, 32'd1, "R3 status set");
    expect_irq(1'b0, "R6 irq masked");
    wr(3'd4, 32'd1);
    expect_irq(1'b1, "R6 irq unmasked");
    ticks(1);
    expect_rd(3'd7, 32'd6, "R3 counts past match");

    // R5 clear
    wr(3'd6, 32'd1);
    expect_rd(3'd5, 32'd0, "R5 status cleared");
    expect_irq(1'b0, "R6 irq after clear");

    // R4 load and wrap
    wr(3'd1, 32'hFFFF_FFFE);
    expect_rd(3'd7, 32'hFFFF_FFFE, "R4 load value");
    ticks(1);
    expect_rd(3'd7, 32'hFFFF_FFFF, "R4 step to all-ones");
    ticks(1);
    expect_rd(3'd7, 32'd0, "R4 wrap to zero");

    // R7 stall
    dbg_halt_i = 1'b1;
    ticks(1);
    expect_rd(3'd7, 32'd1, "R7 halt without stall counts");
    wr(3'd3, 32'h7);
    ticks(2);
    expect_rd(3'd7, 32'd1, "R7 stalled under halt");
    dbg_halt_i = 1'b0;
    ticks(1);
    expect_rd(3'd7, 32'd2, "R7 resumes after halt");

    // R9 set over clear in the same cycle
    wr(3'd1, 32'd10);
    wr(3'd2, 32'd11);
    ticks(1);
    expect_rd(3'd5, 32'd1, "R9 setup status");
    wr(3'd2, 32'd12);
    @(negedge clk_i) ref_clk_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    we_i = 1'b1; waddr_i = 3'd6; wdata_i = 32'd1;
    @(negedge clk_i);
    we_i = 1'b0;
    repeat (3) @(negedge clk_i);
    ref_clk_i = 1'b0;
    repeat (4) @(negedge clk_i);
    expect_rd(3'd7, 32'd12, "R9 count at new match");
    expect_rd(3'd5, 32'd1, "R9 set wins over clear");

    // R8 run bit clear
    wr(3'd3, 32'h2);
    ticks(2);
    expect_rd(3'd7, 32'd12, "R8 run clear holds");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule